// File: doc/BRIEF.md
# Twin Down-Counting Event Timer

This block holds two independent down-counters behind a small register map on a synchronous bus. Each counter has an enable, an auto-reload option, a choice of count clock and a shift-coded prescaler. The count clock is either the block clock divided by a power of two or an external reference tick enable. That enable is already synchronised into the block clock domain and is high for one cycle per reference period. When a counter reaches zero on a count tick, it raises a sticky expiry flag. Each flag drives that timer's level interrupt.

Software typically uses one timer as a free-running time base: both the reload and start values are all ones, and auto-reload is on. The other timer serves as an event source, either periodic with reload N-1 or one-shot. Expiry flags are cleared by writing a zero to the flag bit. Writing a one leaves the flag as it is, so one flag can be acknowledged without touching the other.

Top module: `twin_dntimer`

## Requirements
- R1: After reset, every mapped register reads zero and both `irq` bits are low.
- R2: The control register at byte address 0x00 keeps only these bits: bit 0 enables timer 0, bit 1 enables its auto-reload, bit 2 enables timer 1, bit 3 enables its auto-reload, bit 11 (timer 0) and bit 12 (timer 1) select the reference tick, bits 21:19 hold the prescale shift of timer 0 and bits 24:22 that of timer 1. All other bits read zero (stored mask 0x01F8180F).
- R3: The value registers sit at 0x14 (timer 0) and 0x1C (timer 1). A write loads the counter at that clock edge, and the loaded value wins over a count tick in the same cycle. A read returns the live count.
- R4: An enabled, running counter decrements by one on each count tick. A disabled counter holds its value.
- R5: With the reference select clear, a prescale shift n gives one count tick every 2^n block clocks. With auto-reload and reload value R, expiries then come every (R+1)*2^n clocks.
- R6: With the reference select set, the counter steps only in cycles where `ref_tick` is high, and the prescale field has no effect.
- R7: The reload registers sit at 0x10 (timer 0) and 0x18 (timer 1). A count tick with the counter at zero is an expiry. With auto-reload on, the counter then loads the reload value. Writing a reload register leaves the running count unchanged.
- R8: With auto-reload off, an expiry leaves the counter at zero and stopped. No further expiry occurs until the value register is written again. After reset, such a timer stays stopped until its first value write.
- R9: The status register at 0x04 holds the expiry flag of timer 0 in bit 0 and of timer 1 in bit 8. An expiry sets the flag, writing 0 to the bit clears it, and writing 1 leaves it unchanged.
- R10: `irq[i]` equals the flag of timer i. When a clearing status write and an expiry of the same timer fall in the same cycle, the flag ends up set.
- R11: Any address other than 0x00, 0x04, 0x10, 0x14, 0x18 and 0x1C reads zero (unaligned addresses included), and writes to it change no register.
- R12: The two timers are independent: counting, reloading or clearing one never changes the count, reload or flag of the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block (fabric) clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One-cycle enable per reference clock period, already synchronised |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, acts at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, valid in the same cycle |
| irq | output | 2 | Level interrupt per timer, bit i for timer i |

## Verification
A wrong count or a missed decrement shows up on the next value-register read, one clock after the tick that should have moved it. A prescaler or reference-select fault does not show in any single read, only in the spacing of interrupts, so the sweep over all shift values measures the gap between two consecutive expiries. A wrong one-shot state or a lost set/clear priority shows on `irq` at the very next edge after the expiry tick. The bench therefore drives the reference tick one pulse at a time and reads back right after each pulse.

// File: rtl/twin_dntimer_pkg.sv
package twin_dntimer_pkg;

  localparam int NUM_TMR = 2;
  localparam int DATA_W  = 32;
  localparam int PRE_W   = 3;
  localparam int PCNT_W  = (1 << PRE_W) - 1;

  localparam int OFF_CTRL = 'h00;
  localparam int OFF_STAT = 'h04;

  function automatic int en_bit(input int t);
    return 2 * t;
  endfunction

  function automatic int rl_bit(input int t);
    return 2 * t + 1;
  endfunction

  function automatic int fix_bit(input int t);
    return 11 + t;
  endfunction

  function automatic int pre_lsb(input int t);
    return 19 + PRE_W * t;
  endfunction

  function automatic int flag_bit(input int t);
    return 8 * t;
  endfunction

  function automatic int reload_off(input int t);
    return 'h10 + 8 * t;
  endfunction

  function automatic int value_off(input int t);
    return 'h14 + 8 * t;
  endfunction

  function automatic logic [DATA_W-1:0] ctrl_mask();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int t = 0; t < NUM_TMR; t++) begin
      m[en_bit(t)]  = 1'b1;
      m[rl_bit(t)]  = 1'b1;
      m[fix_bit(t)] = 1'b1;
      for (int b = 0; b < PRE_W; b++) m[pre_lsb(t) + b] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic pre_hit(input logic [PCNT_W-1:0] cnt,
                                   input logic [PRE_W-1:0]  shift);
    logic [PCNT_W:0] full;
    full = ((PCNT_W+1)'(1) << shift) - (PCNT_W+1)'(1);
    return (cnt & full[PCNT_W-1:0]) == full[PCNT_W-1:0];
  endfunction

  function automatic logic is_mapped(input int a);
    logic hit;
    hit = (a == OFF_CTRL) || (a == OFF_STAT);
    for (int t = 0; t < NUM_TMR; t++)
      hit = hit || (a == reload_off(t)) || (a == value_off(t));
    return hit;
  endfunction

endpackage

// File: rtl/tdt_prescaler.sv
module tdt_prescaler #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/tdt_tick_sel.sv
module tdt_tick_sel
  import twin_dntimer_pkg::*;
(
  input  logic [PCNT_W-1:0] pre_cnt,
  input  logic [PRE_W-1:0]  shift,
  input  logic              use_ref,
  input  logic              ref_tick,
  output logic              tick
);
  logic div_tick;
  assign div_tick = pre_hit(pre_cnt, shift);
  assign tick     = use_ref ? ref_tick : div_tick;
endmodule

// File: rtl/tdt_counter.sv
module tdt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             reload_en,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] count,
  output logic             step,
  output logic             expire
);
  logic armed;
  logic active;

  assign active = enable && (reload_en || armed);
  assign step   = active && tick && !load;
  assign expire = step && (count == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      armed <= 1'b0;
    end else if (load) begin
      count <= load_val;
      armed <= 1'b1;
    end else if (expire) begin
      if (reload_en) count <= reload_val;
      else           armed <= 1'b0;
    end else if (step) begin
      count <= count - CNT_W'(1);
    end
  end
endmodule

// File: rtl/tdt_flag.sv
module tdt_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= set || (flag && !clr);
  end
endmodule

// File: rtl/twin_dntimer.sv
module twin_dntimer
  import twin_dntimer_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_TMR-1:0] irq
);
  localparam logic [DATA_W-1:0] CTL_MASK = ctrl_mask();

  logic [DATA_W-1:0]               ctrl_q;
  logic [NUM_TMR-1:0][CNT_W-1:0]   rld_q;
  logic [NUM_TMR-1:0][CNT_W-1:0]   cnt_q;
  logic [NUM_TMR-1:0]              ev_expire;
  logic [NUM_TMR-1:0]              ev_step;
  logic [NUM_TMR-1:0]              ev_load;
  logic [NUM_TMR-1:0]              ev_tick;
  logic [NUM_TMR-1:0]              flag_q;
  logic [NUM_TMR-1:0]              rl_en;
  logic [PCNT_W-1:0]               pre_cnt;
  logic                            wr_ctrl;
  logic                            wr_stat;

  assign wr_ctrl = bus_we && (bus_addr == ADDR_W'(OFF_CTRL));
  assign wr_stat = bus_we && (bus_addr == ADDR_W'(OFF_STAT));

  always_ff @(posedge clk) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= bus_wdata & CTL_MASK;
  end

  tdt_prescaler #(.W(PCNT_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .cnt   (pre_cnt)
  );

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
    assign rl_en[g]   = ctrl_q[rl_bit(g)];
    assign ev_load[g] = bus_we && (bus_addr == ADDR_W'(value_off(g)));

    always_ff @(posedge clk) begin
      if (!rst_n)
        rld_q[g] <= '0;
      else if (bus_we && (bus_addr == ADDR_W'(reload_off(g))))
        rld_q[g] <= bus_wdata[CNT_W-1:0];
    end

    tdt_tick_sel u_sel (
      .pre_cnt  (pre_cnt),
      .shift    (ctrl_q[pre_lsb(g) +: PRE_W]),
      .use_ref  (ctrl_q[fix_bit(g)]),
      .ref_tick (ref_tick),
      .tick     (ev_tick[g])
    );

    tdt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (ctrl_q[en_bit(g)]),
      .reload_en  (rl_en[g]),
      .tick       (ev_tick[g]),
      .load       (ev_load[g]),
      .load_val   (bus_wdata[CNT_W-1:0]),
      .reload_val (rld_q[g]),
      .count      (cnt_q[g]),
      .step       (ev_step[g]),
      .expire     (ev_expire[g])
    );

    tdt_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (ev_expire[g]),
      .clr   (wr_stat && !bus_wdata[flag_bit(g)]),
      .flag  (flag_q[g])
    );

    assign irq[g] = flag_q[g];
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(OFF_CTRL)) bus_rdata = ctrl_q;
    if (bus_addr == ADDR_W'(OFF_STAT)) begin
      for (int t = 0; t < NUM_TMR; t++) bus_rdata[flag_bit(t)] = flag_q[t];
    end
    for (int t = 0; t < NUM_TMR; t++) begin
      if (bus_addr == ADDR_W'(reload_off(t))) bus_rdata = DATA_W'(rld_q[t]);
      if (bus_addr == ADDR_W'(value_off(t)))  bus_rdata = DATA_W'(cnt_q[t]);
    end
  end
endmodule

// File: rtl/twin_dntimer_chk.sv
module twin_dntimer_chk
  import twin_dntimer_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic [ADDR_W-1:0]               bus_addr,
  input logic                            bus_we,
  input logic [DATA_W-1:0]               bus_wdata,
  input logic [DATA_W-1:0]               bus_rdata,
  input logic [NUM_TMR-1:0]              irq,
  input logic [NUM_TMR-1:0]              ev_expire,
  input logic [NUM_TMR-1:0]              ev_step,
  input logic [NUM_TMR-1:0]              ev_load,
  input logic [NUM_TMR-1:0]              rl_en,
  input logic [NUM_TMR-1:0][CNT_W-1:0]   cnt_q,
  input logic [NUM_TMR-1:0][CNT_W-1:0]   rld_q
);
  p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !is_mapped(int'(bus_addr)) |-> bus_rdata == '0);

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_chk
    p_load_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ev_load[g] |=> cnt_q[g] == $past(bus_wdata[CNT_W-1:0]));

    p_step_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_step[g] && cnt_q[g] != '0) |=> cnt_q[g] == $past(cnt_q[g]) - CNT_W'(1));

    p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_expire[g] && rl_en[g]) |=> cnt_q[g] == $past(rld_q[g]));

    p_oneshot_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_expire[g] && !rl_en[g]) |=> (cnt_q[g] == '0 && !ev_expire[g]));

    p_flag_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ev_expire[g] |=> irq[g]);

    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq[g] && !(bus_we && bus_addr == ADDR_W'(OFF_STAT) && !bus_wdata[flag_bit(g)]))
        |=> irq[g]);

    p_irq_rise_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq[g]) |-> $past(ev_expire[g]));
  end
endmodule

bind twin_dntimer twin_dntimer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq       (irq),
  .ev_expire (ev_expire),
  .ev_step   (ev_step),
  .ev_load   (ev_load),
  .rl_en     (rl_en),
  .cnt_q     (cnt_q),
  .rld_q     (rld_q)
);

// File: tb/sim_twin_dntimer.sv
module sim_twin_dntimer;
  localparam logic [7:0] A_CTL = 8'h00, A_STS = 8'h04;
  localparam logic [7:0] A_RL0 = 8'h10, A_VL0 = 8'h14, A_RL1 = 8'h18, A_VL1 = 8'h1C;
  localparam logic [31:0] EN0 = 32'h1, AR0 = 32'h2, EN1 = 32'h4, AR1 = 32'h8;
  localparam logic [31:0] FX0 = 32'h800, FX1 = 32'h1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_man = 1'b0;
  logic        ref_auto = 1'b0;
  logic        ref_auto_p = 1'b0;
  logic        ref_tick;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  irq;
  int          cyc = 0;
  int          n_chk = 0;
  int          n_err = 0;
  int          ref_div = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (ref_auto) begin
      ref_div    <= (ref_div == 4) ? 0 : ref_div + 1;
      ref_auto_p <= (ref_div == 4);
    end else begin
      ref_div    <= 0;
      ref_auto_p <= 1'b0;
    end
  end
  assign ref_tick = ref_man | ref_auto_p;

  twin_dntimer u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_tick  (ref_tick),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  function automatic logic [31:0] pre0(input int n); return 32'(n) << 19; endfunction
  function automatic logic [31:0] pre1(input int n); return 32'(n) << 22; endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic wr_ref(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1; ref_man = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; ref_man = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic pulse(input int n);
    for (int k = 0; k < n; k++) begin
      ref_man = 1'b1;
      @(negedge clk);
      ref_man = 1'b0;
    end
  endtask

  task automatic wait_irq(input int t, output int when);
    when = -1;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if (irq[t]) begin when = cyc; break; end
    end
  endtask

  task automatic period(input int t, output int p);
    int t0, t1;
    wait_irq(t, t0);
    wr(A_STS, t == 0 ? 32'h100 : 32'h1);
    wait_irq(t, t1);
    p = (t0 < 0 || t1 < 0) ? -1 : t1 - t0;
    wr(A_STS, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] v, v2;
    int p;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_CTL, v); check("R1 ctrl", v, 0);
    rd(A_STS, v); check("R1 status", v, 0);
    rd(A_RL0, v); check("R1 reload0", v, 0);
    rd(A_VL0, v); check("R1 value0", v, 0);
    rd(A_RL1, v); check("R1 reload1", v, 0);
    rd(A_VL1, v); check("R1 value1", v, 0);
    check("R1 irq", {30'b0, irq}, 0);

    // R2 control bit mask
    wr(A_CTL, 32'hFFFF_FFFF); rd(A_CTL, v); check("R2 mask", v, 32'h01F8_180F);
    wr(A_CTL, 32'h0);         rd(A_CTL, v); check("R2 clear", v, 0);

    // R3 load/readback, R4 disabled hold
    wr(A_VL0, 32'h1234); rd(A_VL0, v); check("R3 load", v, 32'h1234);
    repeat (10) @(negedge clk);
    rd(A_VL0, v); check("R4 disabled holds", v, 32'h1234);

    // R8 one-shot does not run after reset without value write: timer1 enabled, no write
    wr(A_CTL, EN1);
    repeat (5) @(negedge clk);
    check("R8 idle after reset", {30'b0, irq}, 0);
    wr(A_CTL, 0);

    // R4 free-running decrement from all ones
    wr(A_RL0, 32'hFFFF_FFFF);
    wr(A_VL0, 32'hFFFF_FFFF);
    wr(A_CTL, EN0 | AR0);
    rd(A_VL0, v);  check("R4 start", v, 32'hFFFF_FFFF);
    @(negedge clk); rd(A_VL0, v); check("R4 step1", v, 32'hFFFF_FFFE);
    @(negedge clk); rd(A_VL0, v2); check("R4 step2", v2, 32'hFFFF_FFFD);
    wr(A_CTL, 0);

    // R5 prescale sweep on timer 0, reload 3
    for (int n = 0; n < 8; n++) begin
      wr(A_RL0, 3); wr(A_VL0, 3); wr(A_STS, 0);
      wr(A_CTL, EN0 | AR0 | pre0(n));
      period(0, p);
      check($sformatf("R5 period shift %0d", n), p, 4 << n);
      wr(A_CTL, 0); wr(A_STS, 0);
    end

    // R6 reference select on timer 1, prescale field ignored; R12 timer 0 untouched
    wr(A_VL0, 32'h55);
    wr(A_RL1, 2); wr(A_VL1, 2); wr(A_STS, 0);
    wr(A_CTL, EN1 | AR1 | FX1 | pre1(7));
    ref_auto = 1'b1;
    period(1, p);
    check("R6 ref period", p, 15);
    ref_auto = 1'b0;
    wr(A_CTL, 0);
    rd(A_VL0, v); check("R12 timer0 value kept", v, 32'h55);
    rd(A_STS, v); check("R12 timer0 flag clear", v, 0);

    // R6 step only with ref_tick; R7 reload write keeps count, reload on expiry
    wr(A_VL0, 50); wr(A_STS, 0);
    wr(A_CTL, EN0 | AR0 | FX0);
    repeat (6) @(negedge clk);
    rd(A_VL0, v); check("R6 no ref no step", v, 50);
    wr(A_RL0, 7);
    rd(A_VL0, v); check("R7 reload write no disturb", v, 50);
    pulse(50);
    rd(A_VL0, v); check("R6 steps per ref", v, 0);
    rd(A_STS, v); check("R7 no expiry yet", v, 0);
    pulse(1);
    rd(A_VL0, v); check("R7 reloaded", v, 7);
    rd(A_STS, v); check("R9 flag0 bit0", v, 32'h1);
    check("R10 irq0", {30'b0, irq}, 2'b01);

    // R3 value write wins over tick in same cycle
    wr_ref(A_VL0, 9);
    rd(A_VL0, v); check("R3 write beats tick", v, 9);

    // R10 clear collides with expiry: flag stays set
    wr(A_STS, 32'h100);
    rd(A_STS, v); check("R9 write0 clears", v, 0);
    wr(A_VL0, 0);
    wr_ref(A_STS, 32'h100);
    rd(A_STS, v); check("R10 set beats clear", v, 32'h1);
    check("R10 irq0 level", {30'b0, irq}, 2'b01);
    wr(A_CTL, 0);

    // R8 one-shot on timer 1
    wr(A_STS, 0);
    wr(A_VL1, 3);
    wr(A_CTL, EN1 | FX1);
    pulse(3);
    rd(A_VL1, v); check("R8 reached zero", v, 0);
    rd(A_STS, v); check("R8 not yet expired", v, 0);
    pulse(1);
    rd(A_STS, v); check("R8 expired flag1 bit8", v, 32'h100);
    wr(A_STS, 32'h1);
    pulse(5);
    rd(A_VL1, v); check("R8 stays zero", v, 0);
    rd(A_STS, v); check("R8 no re-expiry", v, 0);
    wr(A_VL1, 2);
    pulse(2);
    rd(A_STS, v); check("R8 rearmed not yet", v, 0);
    pulse(1);
    rd(A_STS, v); check("R8 rearmed expiry", v, 32'h100);
    check("R10 irq1", {30'b0, irq}, 2'b10);

    // R9 write 1 keeps, write 0 clears selectively
    wr(A_VL0, 0); wr(A_CTL, EN0 | AR0 | FX0 | EN1 | FX1);
    pulse(1);
    rd(A_STS, v); check("R9 both set", v, 32'h101);
    wr(A_CTL, 0);
    wr(A_STS, 32'h0000_00FF);
    rd(A_STS, v); check("R9 clear only bit8", v, 32'h1);
    wr(A_STS, 32'hFFFF_FFFF);
    rd(A_STS, v); check("R9 write1 keeps", v, 32'h1);
    wr(A_STS, 0);
    rd(A_STS, v); check("R9 clear bit0", v, 0);

    // R11 unmapped sweep
    wr(A_RL0, 32'hA5); wr(A_VL0, 32'h5A); wr(A_RL1, 32'h3C); wr(A_VL1, 32'hC3);
    for (int a = 0; a < 256; a++) begin
      if (!(a == 'h00 || a == 'h04 || a == 'h10 || a == 'h14 || a == 'h18 || a == 'h1C)) begin
        wr(8'(a), 32'hFFFF_FFFF);
        rd(8'(a), v);
        check($sformatf("R11 read %02h", a), v, 0);
      end
    end
    rd(A_CTL, v); check("R11 ctrl kept", v, 0);
    rd(A_STS, v); check("R11 status kept", v, 0);
    rd(A_RL0, v); check("R11 reload0 kept", v, 32'hA5);
    rd(A_VL0, v); check("R11 value0 kept", v, 32'h5A);
    rd(A_RL1, v); check("R11 reload1 kept", v, 32'h3C);
    rd(A_VL1, v); check("R11 value1 kept", v, 32'hC3);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule